// File: doc/BRIEF.md
# Direct-Mapped Address Translation Unit

This block turns a 32-bit virtual address from one processor into a physical address. It keeps two separate translation tables: one for instruction fetches and one for data loads and stores. Each table has 64 entries, one way, and 8 KB pages. A request carries a virtual address, an access kind, the current privilege level and a translation-enable bit. One cycle later the block returns the physical address, the rights granted for that page, and a fault classification.

There are two fault classes. A miss means the tag did not match or the entry was not valid. A page fault means the entry matched but did not grant the right the access needs. Each fault is also marked as instruction-side or data-side. The virtual address of the most recent faulting request is kept in a capture register.

Software fills the tables through a simple write port. The port selects a side, an entry and either the match word or the translate word of that entry. Page-table walking, caching and exception dispatch are left to the surrounding logic.

Top module: `xlate_unit`

## Requirements
- R1: After reset, `rsp_valid` and `fault_addr` are zero, and every entry in both tables is invalid, so any translated lookup misses.
- R2: When `xlate_en` is 0, the response has `rsp_paddr` equal to the virtual address, `rsp_perm` = 3'b011 ({exec,write,read}: read and write granted) and no fault, whatever the access kind.
- R3: When `xlate_en` is 1 and `priv_sup` is 1, any address below 0x2000 is passed through as in R2 without looking at either table. In user mode, or at 0x2000 and above, the address is translated.
- R4: The page number is `vaddr[31:13]` and the entry index is `vaddr[18:13]`. If bits 31:13 of the entry's match word differ from the page number, the response is a miss.
- R5: Bit 0 of a match word is the entry's valid flag. An entry whose valid flag is 0 produces a miss.
- R6: On a hit that grants the needed right, `rsp_paddr` = {translate word bits 31:13, vaddr[12:0]}, and `rsp_perm` reports the rights of the current privilege level.
- R7: Data translate word bits: bit 6 user read, bit 7 user write, bit 8 supervisor read, bit 9 supervisor write. A load (`req_kind` 0 or 3) without read right, or a store (`req_kind` 1) without write right, raises a page fault. Data entries never report exec.
- R8: Instruction translate word bits: bit 6 supervisor execute, bit 7 user execute. A fetch (`req_kind` 2) uses the instruction table, and a fetch without execute right for the current level raises a page fault. Instruction entries report only exec.
- R9: Every fault sets `rsp_fault`. `rsp_miss` is 1 for a miss and 0 for a page fault. `rsp_iside` is 1 for a fetch and 0 for a load or store. `rsp_miss` and `rsp_iside` are 0 when there is no fault.
- R10: A faulting request loads its virtual address into `fault_addr`, visible with its response. Requests that do not fault leave `fault_addr` unchanged.
- R11: A request accepted at a clock edge gets its response (`rsp_valid` high) in the following cycle. A table write (`wr_side` 0 data / 1 instruction, `wr_sel` 0 match / 1 translate) changes lookups only for requests in later cycles, not for a request in the same cycle.
- R12: On a fault, `rsp_paddr` and `rsp_perm` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A translation request is present |
| req_vaddr | input | 32 | Virtual address of the request |
| req_kind | input | 2 | Access kind: 0 load, 1 store, 2 fetch, 3 treated as load |
| priv_sup | input | 1 | 1 for supervisor level, 0 for user level |
| xlate_en | input | 1 | Translation enable |
| wr_en | input | 1 | Table write strobe |
| wr_side | input | 1 | Table to write: 0 data, 1 instruction |
| wr_sel | input | 1 | Word to write: 0 match, 1 translate |
| wr_index | input | 6 | Entry to write |
| wr_data | input | 32 | Value written |
| rsp_valid | output | 1 | Response valid, one cycle after the request |
| rsp_paddr | output | 32 | Physical address |
| rsp_perm | output | 3 | Granted rights {exec, write, read} |
| rsp_fault | output | 1 | The request faulted |
| rsp_miss | output | 1 | The fault is a miss (0: page fault) |
| rsp_iside | output | 1 | The fault is on the instruction side |
| fault_addr | output | 32 | Virtual address of the most recent faulting request |

## Verification
The hardest situation to reach from the ports is a tag alias. Two virtual pages share one index but differ in their upper page bits, so the entry is valid yet belongs to the other page. The stimulus fills an index and then requests an address with one upper page bit flipped. A second hard case is a write and a lookup to the same entry in the same cycle. The bench drives the write port and the request together, expects the old contents, and then repeats the request to see the new contents. A third case is the edge of the supervisor window: the stimulus uses 0x1FFF and 0x2000 with the same level and also tries each level, so that both sides of the bypass condition are exercised.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
   typedef enum logic [1:0] {
      ACC_LOAD  = 2'd0,
      ACC_STORE = 2'd1,
      ACC_FETCH = 2'd2,
      ACC_RSVD  = 2'd3
   } acc_e;

   // bit position of the lowest right flag inside a translate word
   localparam int FLAG_LO = 6;
   // data side: {sup write, sup read, user write, user read}
   localparam int DATA_FLAG_W = 4;
   // code side: {user exec, sup exec}
   localparam int CODE_FLAG_W = 2;

   typedef struct packed {
      logic ex;
      logic wr;
      logic rd;
   } perm_t;
endpackage

// File: rtl/xlate_table.sv
module xlate_table #(
   parameter int VA_W      = 32,
   parameter int PAGE_BITS = 13,
   parameter int IDX_BITS  = 6,
   parameter int FLAG_LO   = 6,
   parameter int FLAG_W    = 4
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr_en,
   input  logic                      wr_sel,
   input  logic [IDX_BITS-1:0]       wr_index,
   input  logic [VA_W-1:0]           wr_data,
   input  logic [VA_W-PAGE_BITS-1:0] lk_vpn,
   output logic                      lk_tagok,
   output logic                      lk_valid,
   output logic [VA_W-PAGE_BITS-1:0] lk_frame,
   output logic [FLAG_W-1:0]         lk_flags
);
   localparam int TAG_W = VA_W - PAGE_BITS;
   localparam int DEPTH = 1 << IDX_BITS;

   if (FLAG_LO + FLAG_W > PAGE_BITS) begin : g_bad_flags
      $error("xlate_table: right flags must sit inside the page offset");
   end

   logic [TAG_W-1:0]  tag_q   [DEPTH];
   logic [TAG_W-1:0]  frame_q [DEPTH];
   logic [FLAG_W-1:0] flags_q [DEPTH];
   logic [DEPTH-1:0]  vld_q;

   logic [IDX_BITS-1:0] lk_idx;
   assign lk_idx = lk_vpn[IDX_BITS-1:0];

   wire unused_wr_bits = ^wr_data[PAGE_BITS-1:1];

   always_ff @(posedge clk) begin
      if (wr_en) begin
         if (!wr_sel) begin
            tag_q[wr_index] <= wr_data[VA_W-1:PAGE_BITS];
         end else begin
            frame_q[wr_index] <= wr_data[VA_W-1:PAGE_BITS];
            flags_q[wr_index] <= wr_data[FLAG_LO +: FLAG_W];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q <= '0;
      end else if (wr_en && !wr_sel) begin
         vld_q[wr_index] <= wr_data[0];
      end
   end

   always_comb begin
      lk_valid = vld_q[lk_idx];
      lk_tagok = (tag_q[lk_idx] == lk_vpn);
      lk_frame = frame_q[lk_idx];
      lk_flags = flags_q[lk_idx];
   end

   // R1
   vld_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (vld_q == '0));

   // R11
   vld_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_sel) |=> (vld_q[$past(wr_index)] == $past(wr_data[0])));
endmodule

// File: rtl/xlate_perm.sv
module xlate_perm
   import xlate_pkg::*;
#(
   parameter bit IS_CODE = 1'b0,
   parameter int FLAG_W  = 4
) (
   input  logic [FLAG_W-1:0] flags,
   input  logic              sup,
   output perm_t             perm
);
   if (IS_CODE) begin : g_code
      if (FLAG_W != CODE_FLAG_W) begin : g_bad_w
         $error("xlate_perm: code side expects two flags");
      end
      always_comb begin
         perm.rd = 1'b0;
         perm.wr = 1'b0;
         perm.ex = sup ? flags[0] : flags[1];
      end
   end else begin : g_data
      if (FLAG_W != DATA_FLAG_W) begin : g_bad_w
         $error("xlate_perm: data side expects four flags");
      end
      always_comb begin
         perm.ex = 1'b0;
         perm.rd = sup ? flags[2] : flags[0];
         perm.wr = sup ? flags[3] : flags[1];
      end
   end
endmodule

// File: rtl/xlate_unit.sv
module xlate_unit
   import xlate_pkg::*;
#(
   parameter int             VA_W       = 32,
   parameter int             PAGE_BITS  = 13,
   parameter int             IDX_BITS   = 6,
   parameter logic [31:0]    BYPASS_TOP = 32'h0000_2000
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   input  logic [VA_W-1:0]     req_vaddr,
   input  logic [1:0]          req_kind,
   input  logic                priv_sup,
   input  logic                xlate_en,
   input  logic                wr_en,
   input  logic                wr_side,
   input  logic                wr_sel,
   input  logic [IDX_BITS-1:0] wr_index,
   input  logic [VA_W-1:0]     wr_data,
   output logic                rsp_valid,
   output logic [VA_W-1:0]     rsp_paddr,
   output logic [2:0]          rsp_perm,
   output logic                rsp_fault,
   output logic                rsp_miss,
   output logic                rsp_iside,
   output logic [VA_W-1:0]     fault_addr
);
   localparam int TAG_W = VA_W - PAGE_BITS;

   if (PAGE_BITS + IDX_BITS > VA_W) begin : g_bad_geom
      $error("xlate_unit: page and index bits exceed the address width");
   end
   if (VA_W > 32) begin : g_bad_va
      $error("xlate_unit: bypass limit is held in 32 bits");
   end

   logic [TAG_W-1:0] vpn;
   assign vpn = req_vaddr[VA_W-1:PAGE_BITS];

   logic [1:0]       side_tagok;
   logic [1:0]       side_valid;
   logic [TAG_W-1:0] side_frame [2];
   perm_t            side_perm  [2];

   // side 0 holds data entries, side 1 instruction entries
   for (genvar s = 0; s < 2; s++) begin : g_side
      localparam int FW = (s == 1) ? CODE_FLAG_W : DATA_FLAG_W;
      logic [FW-1:0] flags;
      logic          wr_here;
      assign wr_here = wr_en && (wr_side == s[0]);

      xlate_table #(
         .VA_W(VA_W), .PAGE_BITS(PAGE_BITS), .IDX_BITS(IDX_BITS),
         .FLAG_LO(FLAG_LO), .FLAG_W(FW)
      ) u_tab (
         .clk(clk), .rst_n(rst_n), .wr_en(wr_here), .wr_sel(wr_sel),
         .wr_index(wr_index), .wr_data(wr_data), .lk_vpn(vpn),
         .lk_tagok(side_tagok[s]), .lk_valid(side_valid[s]),
         .lk_frame(side_frame[s]), .lk_flags(flags)
      );

      xlate_perm #(.IS_CODE(s == 1), .FLAG_W(FW)) u_perm (
         .flags(flags), .sup(priv_sup), .perm(side_perm[s])
      );
   end

   logic            is_fetch, is_store, bypass, miss_n, pf_n, fault_n, need_ok;
   logic            sel;
   perm_t           perm_sel, perm_n;
   logic [VA_W-1:0] paddr_n;

   always_comb begin
      is_fetch = (acc_e'(req_kind) == ACC_FETCH);
      is_store = (acc_e'(req_kind) == ACC_STORE);
      sel      = is_fetch;
      bypass   = !xlate_en || (priv_sup && (32'(req_vaddr) < BYPASS_TOP));
      perm_sel = side_perm[sel];
      need_ok  = is_fetch ? perm_sel.ex : (is_store ? perm_sel.wr : perm_sel.rd);
      miss_n   = !bypass && !(side_tagok[sel] && side_valid[sel]);
      pf_n     = !bypass && !miss_n && !need_ok;
      fault_n  = miss_n || pf_n;
      if (bypass) begin
         paddr_n = req_vaddr;
         perm_n  = '{ex: 1'b0, wr: 1'b1, rd: 1'b1};
      end else if (fault_n) begin
         paddr_n = '0;
         perm_n  = '0;
      end else begin
         paddr_n = {side_frame[sel], req_vaddr[PAGE_BITS-1:0]};
         perm_n  = perm_sel;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid  <= 1'b0;
         rsp_paddr  <= '0;
         rsp_perm   <= '0;
         rsp_fault  <= 1'b0;
         rsp_miss   <= 1'b0;
         rsp_iside  <= 1'b0;
         fault_addr <= '0;
      end else begin
         rsp_valid <= req_valid;
         if (req_valid) begin
            rsp_paddr <= paddr_n;
            rsp_perm  <= perm_n;
            rsp_fault <= fault_n;
            rsp_miss  <= miss_n;
            rsp_iside <= fault_n && is_fetch;
            if (fault_n) begin
               fault_addr <= req_vaddr;
            end
         end
      end
   end

   // R11
   rsp_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);

   // R2
   no_xlate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !xlate_en) |=> (rsp_paddr == $past(req_vaddr) && !rsp_fault));

   // R9
   miss_implies_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> ((rsp_miss || rsp_iside) ? rsp_fault : 1'b1));

   // R10
   fault_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && fault_n) |=> (fault_addr == $past(req_vaddr)));

   // R12
   fault_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_fault) |-> (rsp_paddr == '0 && rsp_perm == '0));
endmodule

// File: tb/xlate_unit_bench.sv
module xlate_unit_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [31:0] req_vaddr = '0;
   logic [1:0]  req_kind = '0;
   logic        priv_sup = 1'b0;
   logic        xlate_en = 1'b0;
   logic        wr_en = 1'b0;
   logic        wr_side = 1'b0;
   logic        wr_sel = 1'b0;
   logic [5:0]  wr_index = '0;
   logic [31:0] wr_data = '0;
   logic        rsp_valid, rsp_fault, rsp_miss, rsp_iside;
   logic [31:0] rsp_paddr, fault_addr;
   logic [2:0]  rsp_perm;

   always #5 clk = ~clk;

   xlate_unit u_xlate_unit (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
      .req_kind(req_kind), .priv_sup(priv_sup), .xlate_en(xlate_en),
      .wr_en(wr_en), .wr_side(wr_side), .wr_sel(wr_sel), .wr_index(wr_index),
      .wr_data(wr_data), .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
      .rsp_perm(rsp_perm), .rsp_fault(rsp_fault), .rsp_miss(rsp_miss),
      .rsp_iside(rsp_iside), .fault_addr(fault_addr)
   );

   typedef struct {
      logic [31:0] pa;
      logic [2:0]  perm;
      logic        f, m, i;
      logic [31:0] fa;
      string       tag;
   } exp_t;

   exp_t        sb[$];
   logic [31:0] mw [2][64];
   logic [31:0] tw [2][64];
   logic [31:0] last_fa = '0;
   int          checks = 0;
   int          fails = 0;

   function automatic exp_t model(input logic [31:0] va, input logic [1:0] kind,
                                  input logic sup, input logic en, input string tag);
      exp_t e;
      int   s = (kind == 2'd2) ? 1 : 0;
      logic [5:0] ix = va[18:13];
      logic [31:0] m = mw[s][ix];
      logic [31:0] t = tw[s][ix];
      logic ex, wr, rd, ok;
      e.tag = tag;
      e.f = 0; e.m = 0; e.i = 0;
      if (!en || (sup && va < 32'h2000)) begin
         e.pa = va; e.perm = 3'b011;
      end else if (m[31:13] != va[31:13] || !m[0]) begin
         e.f = 1; e.m = 1; e.i = (s == 1);
      end else begin
         ex = (s == 1) ? (sup ? t[6] : t[7]) : 1'b0;
         rd = (s == 0) ? (sup ? t[8] : t[6]) : 1'b0;
         wr = (s == 0) ? (sup ? t[9] : t[7]) : 1'b0;
         ok = (s == 1) ? ex : ((kind == 2'd1) ? wr : rd);
         if (ok) begin
            e.pa = {t[31:13], va[12:0]}; e.perm = {ex, wr, rd};
         end else begin
            e.f = 1; e.i = (s == 1);
         end
      end
      if (e.f) begin
         e.pa = '0; e.perm = '0; last_fa = va;
      end
      e.fa = last_fa;
      return e;
   endfunction

   task automatic access(input logic [31:0] va, input logic [1:0] kind,
                         input logic sup, input logic en, input string tag);
      @(negedge clk);
      wr_en = 0;
      req_valid = 1; req_vaddr = va; req_kind = kind; priv_sup = sup; xlate_en = en;
      sb.push_back(model(va, kind, sup, en, tag));
   endtask

   task automatic set_write(input logic side, input logic sel, input logic [5:0] ix,
                            input logic [31:0] d);
      wr_en = 1; wr_side = side; wr_sel = sel; wr_index = ix; wr_data = d;
   endtask

   task automatic shadow(input logic side, input logic sel, input logic [5:0] ix,
                         input logic [31:0] d);
      if (!sel) mw[side][ix] = d; else tw[side][ix] = d;
   endtask

   task automatic write(input logic side, input logic sel, input logic [5:0] ix,
                        input logic [31:0] d);
      @(negedge clk);
      req_valid = 0;
      set_write(side, sel, ix, d);
      shadow(side, sel, ix, d);
   endtask

   // request and table write in one cycle: the request sees old contents (R11)
   task automatic write_and_access(input logic side, input logic sel, input logic [5:0] ix,
                                   input logic [31:0] d, input logic [31:0] va,
                                   input logic [1:0] kind, input logic sup, input string tag);
      @(negedge clk);
      set_write(side, sel, ix, d);
      req_valid = 1; req_vaddr = va; req_kind = kind; priv_sup = sup; xlate_en = 1;
      sb.push_back(model(va, kind, sup, 1'b1, tag));
      shadow(side, sel, ix, d);
   endtask

   task automatic idle();
      @(negedge clk);
      req_valid = 0; wr_en = 0;
   endtask

   task automatic report(input string summary);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      if (summary.len() > 0) $display("%s", summary);
      $finish;
   endtask

   function automatic logic [31:0] mkmatch(input logic [18:0] vpn, input logic v);
      return {vpn, 12'b0, v};
   endfunction

   function automatic logic [31:0] mktrans(input logic [18:0] frame, input logic [3:0] fl);
      return {frame, 3'b0, fl, 6'b0};
   endfunction

   // monitor: compare each response against the oldest expected item
   always @(negedge clk) begin
      if (rst_n && rsp_valid) begin
         exp_t e;
         checks++;
         if (sb.size() == 0) begin
            fails++;
            $display("FAIL R11 unexpected response act_pa=%h exp=none", rsp_paddr);
         end else begin
            e = sb.pop_front();
            if (rsp_paddr !== e.pa || rsp_perm !== e.perm || rsp_fault !== e.f ||
                rsp_miss !== e.m || rsp_iside !== e.i || fault_addr !== e.fa) begin
               fails++;
               $display("FAIL %s act pa=%h perm=%b f=%b m=%b i=%b fa=%h exp pa=%h perm=%b f=%b m=%b i=%b fa=%h",
                        e.tag, rsp_paddr, rsp_perm, rsp_fault, rsp_miss, rsp_iside, fault_addr,
                        e.pa, e.perm, e.f, e.m, e.i, e.fa);
            end
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired act=running exp=finished");
      report("");
   end

   localparam logic [18:0] VPN_A = {13'h0AB, 6'd5};
   localparam logic [18:0] VPN_C = {13'h155, 6'd9};

   initial begin
      for (int s = 0; s < 2; s++)
         for (int k = 0; k < 64; k++) begin
            mw[s][k] = '0; tw[s][k] = '0;
         end
      repeat (3) @(negedge clk);
      checks++;
      if (rsp_valid !== 1'b0 || fault_addr !== 32'h0) begin
         fails++;
         $display("FAIL R1 reset act valid=%b fa=%h exp valid=0 fa=0", rsp_valid, fault_addr);
      end
      rst_n = 1;

      // R1: tables empty after reset
      access({VPN_A, 13'h0}, 2'd0, 1'b1, 1'b1, "R1 data lookup after reset");
      access({VPN_C, 13'h4}, 2'd2, 1'b0, 1'b1, "R1 fetch lookup after reset");

      // R2: translation disabled
      access(32'hDEAD_BEEF, 2'd0, 1'b0, 1'b0, "R2 load untranslated");
      access(32'h1234_5678, 2'd1, 1'b1, 1'b0, "R2 store untranslated");
      access(32'hFFFF_E001, 2'd2, 1'b0, 1'b0, "R2 fetch untranslated");
      access(32'h0000_1000, 2'd3, 1'b0, 1'b0, "R2 kind3 untranslated");

      // R3: supervisor low window
      access(32'h0000_1FFF, 2'd0, 1'b1, 1'b1, "R3 sup below window");
      access(32'h0000_0000, 2'd2, 1'b1, 1'b1, "R3 sup fetch at zero");
      access(32'h0000_1FFF, 2'd1, 1'b0, 1'b1, "R3 user below window translated");
      access(32'h0000_2000, 2'd0, 1'b1, 1'b1, "R3 sup at window edge translated");

      // R6/R7: data entry with user read and supervisor read only
      write(1'b0, 1'b0, 6'd5, mkmatch(VPN_A, 1'b1));
      write(1'b0, 1'b1, 6'd5, mktrans(19'h4_5678, 4'b0101));
      access({VPN_A, 13'h123}, 2'd0, 1'b0, 1'b1, "R6 user load hit");
      access({VPN_A, 13'h1FF}, 2'd0, 1'b1, 1'b1, "R7 sup load hit");
      access({VPN_A, 13'h010}, 2'd1, 1'b0, 1'b1, "R7 user store page fault");
      access({VPN_A, 13'h020}, 2'd1, 1'b1, 1'b1, "R7 sup store page fault");
      access({VPN_A, 13'h030}, 2'd3, 1'b0, 1'b1, "R10 kind3 load hit keeps fault addr");

      // R11: same-cycle write sees old flags, next request sees new
      write_and_access(1'b0, 1'b1, 6'd5, mktrans(19'h0_0F0F, 4'b1010),
                       {VPN_A, 13'h040}, 2'd0, 1'b0, "R11 same-cycle write uses old entry");
      access({VPN_A, 13'h040}, 2'd0, 1'b0, 1'b1, "R7 user load after write page fault");
      access({VPN_A, 13'h050}, 2'd1, 1'b1, 1'b1, "R7 sup store after write hit");
      access({VPN_A, 13'h060}, 2'd1, 1'b0, 1'b1, "R7 user store after write hit");

      // R4: alias on the same index with a different upper page bit
      access({VPN_A ^ 19'h0_0400, 13'h123}, 2'd0, 1'b1, 1'b1, "R4 tag alias miss");
      // R5: clear the valid flag with a matching tag
      write(1'b0, 1'b0, 6'd5, mkmatch(VPN_A, 1'b0));
      access({VPN_A, 13'h123}, 2'd1, 1'b1, 1'b1, "R5 invalid entry miss");

      // R8: instruction entry with supervisor execute only
      write(1'b1, 1'b0, 6'd9, mkmatch(VPN_C, 1'b1));
      write(1'b1, 1'b1, 6'd9, mktrans(19'h7_0001, 4'b0001));
      access({VPN_C, 13'h0AC}, 2'd2, 1'b1, 1'b1, "R8 sup fetch hit");
      access({VPN_C, 13'h0B0}, 2'd2, 1'b0, 1'b1, "R8 user fetch page fault");
      access({VPN_C, 13'h0B4}, 2'd0, 1'b1, 1'b1, "R9 load on code page misses data side");
      write(1'b1, 1'b1, 6'd9, mktrans(19'h7_0001, 4'b0010));
      access({VPN_C, 13'h0B8}, 2'd2, 1'b0, 1'b1, "R8 user fetch hit after write");
      access({VPN_C, 13'h0BC}, 2'd2, 1'b1, 1'b1, "R8 sup fetch page fault");
      access(32'h0000_0004, 2'd1, 1'b1, 1'b1, "R10 bypass keeps fault addr");
      idle();

      repeat (3) @(negedge clk);
      checks++;
      if (sb.size() != 0) begin
         fails++;
         $display("FAIL R11 missing responses act=%0d exp=0", sb.size());
      end
      report("");
   end
endmodule